// File: doc/BRIEF.md
# Codirectional Receive Decoder and Slip Buffer

This block turns a 64 kb/s codirectional line signal, already split into two active-low rails, into octets that are replayed as 8-bit bursts inside a chosen time slot of a local 2.048 MHz PCM stream. A separate clock-recovery stage delivers one strobe per half bit period, together with a flag that marks the second half. From these samples the block decodes each bit. It finds octet boundaries from polarity violations and keeps counting octets on its own when violations stop arriving. It also raises an alarm once enough boundaries in a row have gone missing.

Finished octets go into two registers used in alternation. At the start of each selected time slot the newest unread octet is taken. When the local side runs slow, older unread octets are overwritten and lost. When it runs fast, the previous octet is sent again. Octet boundaries are never broken by these slips. Output blanking comes in two forms: a direct blanking input, and supervised blanking that applies to octets that closed without a violation.

Everything runs on one system clock. The line side and the PCM side are strobe-qualified streams: a strobe acts as the valid, and no ready exists. Neither a line nor a TDM bus can be stalled, so the block never applies back-pressure and accepts every strobe in the cycle it arrives.

Top module: `codir_rx`

## Requirements
- R1: On a half-bit strobe, a low `line_p_n` counts as a positive mark. Otherwise a low `line_n_n` counts as a negative mark. Both rails high means no mark. A block takes the polarity of its first-half mark.
- R2: A bit decodes as 1 when its second half (`line_half`=1) carries no mark, and as 0 otherwise.
- R3: A bit whose first-half mark has the same polarity as the most recent earlier marked block is a violation. A violation closes the current octet, and the next bit becomes bit 0 of a new octet.
- R4: With no violation, an octet closes after its 8th bit counted from the last boundary. A violation on any bit other than the 8th realigns to that bit, discards the partial octet and leaves the miss count unchanged.
- R5: `alarm` goes high when 8 consecutive octets close without a violation. It clears when an octet closes with a violation on its 8th bit. It changes two clock cycles after the strobe of the closing bit's second half.
- R6: `ts_sel`=1 selects envelope `ts1`, and 0 selects `ts2`. A slot starts at a `pcm_stb` with the envelope high, where the previous `pcm_stb` saw it low. From the cycle after that strobe, `pcm_out` carries bit 0 (first received). Each further `pcm_stb` inside the envelope moves to the next bit. After 8 bits, or after a strobe with the envelope low, `pcm_out` is 1.
- R7: At slot start the block takes the newest closed octet not yet read. Older unread octets are dropped. If nothing is unread, the octet sent last is repeated. Until the first octet arrives, the output is all ones. An octet closed by the strobe at cycle t can be taken by a slot start at cycle t+3 or later.
- R8: While `blank` is high, `pcm_out` is 1 in the same cycle.
- R9: If the octet sent in a slot closed without a violation and `sup_n` is low at slot start, that burst is all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_stb | input | 1 | Half-bit sample strobe from clock recovery |
| line_half | input | 1 | 1 when the strobe is for the second half of a bit |
| line_p_n | input | 1 | Positive-mark rail, active low |
| line_n_n | input | 1 | Negative-mark rail, active low |
| pcm_stb | input | 1 | One-cycle strobe on each rising edge of the local 2.048 MHz clock |
| ts1 | input | 1 | Time-slot envelope 1 |
| ts2 | input | 1 | Time-slot envelope 2 |
| ts_sel | input | 1 | Envelope select, 1 picks ts1 |
| sup_n | input | 1 | Supervised blanking enable, active low |
| blank | input | 1 | Forces pcm_out to 1 |
| pcm_out | output | 1 | Serial PCM data |
| alarm | output | 1 | Missing-violation alarm |

## Verification
The properties assume that line strobes are single-cycle pulses at least three cycles apart, with each first-half strobe followed by a second-half one. They also assume that the envelopes and `ts_sel` change only in `pcm_stb` cycles. The stimulus meets both assumptions: every half bit is a one-cycle strobe followed by five idle cycles, and envelopes are updated only together with a PCM strobe. Slot periods shorter and longer than the octet period drive the repeat and drop paths.

// File: rtl/codir_pkg.sv
package codir_pkg;

  // Decoded content of one half-bit sample.
  typedef enum logic [1:0] {
    MK_NONE = 2'd0,
    MK_POS  = 2'd1,
    MK_NEG  = 2'd2
  } mark_e;

  // How a decoded bit affects octet framing.
  typedef enum logic [1:0] {
    CL_OPEN     = 2'd0,  // octet still filling
    CL_ALIGNED  = 2'd1,  // closed by a violation on its last bit
    CL_FLYWHEEL = 2'd2,  // closed by the counter alone
    CL_REALIGN  = 2'd3   // violation elsewhere: restart framing
  } close_e;

  function automatic mark_e classify(input logic p_n, input logic n_n);
    if (!p_n)      return MK_POS;
    else if (!n_n) return MK_NEG;
    else           return MK_NONE;
  endfunction

endpackage

// File: rtl/codir_line_dec.sv
module codir_line_dec
  import codir_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stb,
  input  logic half,
  input  logic p_n,
  input  logic n_n,
  output logic bit_vld,
  output logic bit_val,
  output logic viol
);

  mark_e mk;
  logic  first_mark_q;
  logic  first_pos_q;
  logic  prev_pos_q;
  logic  have_prev_q;

  always_comb mk = classify(p_n, n_n);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bit_vld      <= 1'b0;
      bit_val      <= 1'b0;
      viol         <= 1'b0;
      first_mark_q <= 1'b0;
      first_pos_q  <= 1'b0;
      prev_pos_q   <= 1'b0;
      have_prev_q  <= 1'b0;
    end else begin
      bit_vld <= 1'b0;
      if (stb && !half) begin
        first_mark_q <= (mk != MK_NONE);
        first_pos_q  <= (mk == MK_POS);
      end
      if (stb && half) begin
        bit_vld      <= 1'b1;
        bit_val      <= (mk == MK_NONE);
        viol         <= first_mark_q && have_prev_q && (first_pos_q == prev_pos_q);
        first_mark_q <= 1'b0;
        if (first_mark_q) begin
          prev_pos_q  <= first_pos_q;
          have_prev_q <= 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/codir_octet_align.sv
module codir_octet_align
  import codir_pkg::*;
#(
  parameter int OCT_W      = 8,
  parameter int MISS_LIMIT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bit_vld,
  input  logic             bit_val,
  input  logic             viol,
  output logic             wr,
  output logic [OCT_W-1:0] wr_data,
  output logic             wr_miss,
  output logic             alarm
);

  localparam int POS_W = $clog2(OCT_W);
  localparam int CNT_W = $clog2(MISS_LIMIT + 1);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(OCT_W - 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(MISS_LIMIT);

  logic [POS_W-1:0] pos_q;
  logic [OCT_W-1:0] asm_q;
  logic [OCT_W-1:0] asm_nx;
  logic [CNT_W-1:0] miss_q;
  logic [CNT_W-1:0] miss_nx;
  close_e           kind;

  always_comb begin
    asm_nx        = asm_q;
    asm_nx[pos_q] = bit_val;
  end

  always_comb miss_nx = (miss_q == CNT_TOP) ? miss_q : miss_q + 1'b1;

  always_comb begin
    if (viol)
      kind = (pos_q == POS_LAST) ? CL_ALIGNED : CL_REALIGN;
    else
      kind = (pos_q == POS_LAST) ? CL_FLYWHEEL : CL_OPEN;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pos_q   <= '0;
      asm_q   <= '0;
      miss_q  <= '0;
      wr      <= 1'b0;
      wr_data <= '0;
      wr_miss <= 1'b0;
      alarm   <= 1'b0;
    end else begin
      wr <= 1'b0;
      if (bit_vld) begin
        unique case (kind)
          CL_OPEN: begin
            asm_q <= asm_nx;
            pos_q <= pos_q + 1'b1;
          end
          CL_ALIGNED: begin
            wr      <= 1'b1;
            wr_data <= asm_nx;
            wr_miss <= 1'b0;
            miss_q  <= '0;
            alarm   <= 1'b0;
            pos_q   <= '0;
          end
          CL_FLYWHEEL: begin
            wr      <= 1'b1;
            wr_data <= asm_nx;
            wr_miss <= 1'b1;
            miss_q  <= miss_nx;
            alarm   <= (miss_nx == CNT_TOP);
            pos_q   <= '0;
          end
          CL_REALIGN: begin
            pos_q <= '0;
          end
          default: pos_q <= pos_q;
        endcase
      end
    end
  end

endmodule

// File: rtl/codir_slip_buf.sv
module codir_slip_buf #(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [OCT_W-1:0] wr_data,
  input  logic             wr_miss,
  input  logic             take,
  output logic             rd_avail,
  output logic [OCT_W-1:0] rd_data,
  output logic             rd_miss
);

  localparam int NREG = 2;

  logic [NREG-1:0]  fresh;
  logic [OCT_W-1:0] slot_data [NREG];
  logic [NREG-1:0]  slot_miss;
  logic             last_wr_q;
  logic             wr_idx;

  always_comb wr_idx = ~last_wr_q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic             fresh_q;
    logic [OCT_W-1:0] data_q;
    logic             miss_q;
    logic             hit;

    always_comb hit = wr && (wr_idx == 1'(g));

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        fresh_q <= 1'b0;
        data_q  <= '1;
        miss_q  <= 1'b0;
      end else begin
        if (hit) begin
          data_q  <= wr_data;
          miss_q  <= wr_miss;
          fresh_q <= 1'b1;
        end else if (take) begin
          fresh_q <= 1'b0;
        end
      end
    end

    assign fresh[g]     = fresh_q;
    assign slot_data[g] = data_q;
    assign slot_miss[g] = miss_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  last_wr_q <= 1'b1;
    else if (wr) last_wr_q <= wr_idx;
  end

  always_comb begin
    rd_avail = |fresh;
    rd_data  = slot_data[last_wr_q];
    rd_miss  = slot_miss[last_wr_q];
  end

endmodule

// File: rtl/codir_slot_out.sv
module codir_slot_out #(
  parameter int OCT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pcm_stb,
  input  logic             ts1,
  input  logic             ts2,
  input  logic             ts_sel,
  input  logic             sup_n,
  input  logic             blank,
  input  logic             rd_avail,
  input  logic [OCT_W-1:0] rd_data,
  input  logic             rd_miss,
  output logic             take,
  output logic             pcm_out
);

  localparam int IDX_W = $clog2(OCT_W + 1);
  localparam int SEL_W = $clog2(OCT_W);
  localparam logic [IDX_W-1:0] IDX_END = IDX_W'(OCT_W);

  logic             env;
  logic             env_prev_q;
  logic             start;
  logic [OCT_W-1:0] hold_q;
  logic             hold_miss_q;
  logic [OCT_W-1:0] cur_data;
  logic             cur_force;
  logic             force_q;
  logic [IDX_W-1:0] idx_q;
  logic             bit_q;

  always_comb begin
    env       = ts_sel ? ts1 : ts2;
    start     = pcm_stb && env && !env_prev_q;
    take      = start && rd_avail;
    cur_data  = rd_avail ? rd_data : hold_q;
    cur_force = (rd_avail ? rd_miss : hold_miss_q) && !sup_n;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      env_prev_q  <= 1'b0;
      hold_q      <= '1;
      hold_miss_q <= 1'b0;
      force_q     <= 1'b0;
      idx_q       <= IDX_END;
      bit_q       <= 1'b1;
    end else if (pcm_stb) begin
      env_prev_q <= env;
      if (start) begin
        hold_q      <= cur_data;
        hold_miss_q <= rd_avail ? rd_miss : hold_miss_q;
        force_q     <= cur_force;
        bit_q       <= cur_data[0] | cur_force;
        idx_q       <= IDX_W'(1);
      end else if (env && idx_q < IDX_END) begin
        bit_q <= hold_q[idx_q[SEL_W-1:0]] | force_q;
        idx_q <= idx_q + 1'b1;
      end else begin
        bit_q <= 1'b1;
      end
    end
  end

  always_comb pcm_out = bit_q | blank;

endmodule

// File: rtl/codir_rx.sv
module codir_rx #(
  parameter int OCT_W      = 8,
  parameter int MISS_LIMIT = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_stb,
  input  logic line_half,
  input  logic line_p_n,
  input  logic line_n_n,
  input  logic pcm_stb,
  input  logic ts1,
  input  logic ts2,
  input  logic ts_sel,
  input  logic sup_n,
  input  logic blank,
  output logic pcm_out,
  output logic alarm
);

  logic             dec_vld;
  logic             dec_bit;
  logic             dec_viol;
  logic             oct_wr;
  logic [OCT_W-1:0] oct_data;
  logic             oct_miss;
  logic             take;
  logic             rd_avail;
  logic [OCT_W-1:0] rd_data;
  logic             rd_miss;

  codir_line_dec u_dec (
    .clk     (clk),
    .rst_n   (rst_n),
    .stb     (line_stb),
    .half    (line_half),
    .p_n     (line_p_n),
    .n_n     (line_n_n),
    .bit_vld (dec_vld),
    .bit_val (dec_bit),
    .viol    (dec_viol)
  );

  codir_octet_align #(.OCT_W(OCT_W), .MISS_LIMIT(MISS_LIMIT)) u_align (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_vld (dec_vld),
    .bit_val (dec_bit),
    .viol    (dec_viol),
    .wr      (oct_wr),
    .wr_data (oct_data),
    .wr_miss (oct_miss),
    .alarm   (alarm)
  );

  codir_slip_buf #(.OCT_W(OCT_W)) u_buf (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (oct_wr),
    .wr_data  (oct_data),
    .wr_miss  (oct_miss),
    .take     (take),
    .rd_avail (rd_avail),
    .rd_data  (rd_data),
    .rd_miss  (rd_miss)
  );

  codir_slot_out #(.OCT_W(OCT_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .pcm_stb  (pcm_stb),
    .ts1      (ts1),
    .ts2      (ts2),
    .ts_sel   (ts_sel),
    .sup_n    (sup_n),
    .blank    (blank),
    .rd_avail (rd_avail),
    .rd_data  (rd_data),
    .rd_miss  (rd_miss),
    .take     (take),
    .pcm_out  (pcm_out)
  );

endmodule

// File: rtl/codir_rx_chk.sv
module codir_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic pcm_stb,
  input logic ts1,
  input logic ts2,
  input logic ts_sel,
  input logic blank,
  input logic pcm_out,
  input logic alarm,
  input logic dec_vld,
  input logic dec_viol,
  input logic oct_wr
);

  logic env;
  always_comb env = ts_sel ? ts1 : ts2;

  // R5: the alarm only rises after a decoded bit that carried no violation
  a_r5_alarm_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm) |-> $past(dec_vld && !dec_viol));

  // R5: the alarm only clears after a decoded violation
  a_r5_alarm_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(alarm) |-> $past(dec_vld && dec_viol));

  // R3: an octet is closed only by a bit decoded in the previous cycle
  a_r3_close_follows_bit: assert property (@(posedge clk) disable iff (!rst_n)
    oct_wr |-> $past(dec_vld));

  // R6: after a PCM strobe outside the envelope the line idles high
  a_r6_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pcm_stb && !env) |-> pcm_out);

  // R6: the serial output moves only on PCM strobes or blanking changes
  a_r6_hold_between: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(pcm_stb) && $stable(blank)) |-> $stable(pcm_out));

endmodule

bind codir_rx codir_rx_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .pcm_stb  (pcm_stb),
  .ts1      (ts1),
  .ts2      (ts2),
  .ts_sel   (ts_sel),
  .blank    (blank),
  .pcm_out  (pcm_out),
  .alarm    (alarm),
  .dec_vld  (dec_vld),
  .dec_viol (dec_viol),
  .oct_wr   (oct_wr)
);

// File: tb/codir_rx_bench.sv
module codir_rx_bench;

  localparam int OCT_W      = 8;
  localparam int MISS_LIMIT = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n = 1'b0;
  logic line_stb = 1'b0, line_half = 1'b0, line_p_n = 1'b1, line_n_n = 1'b1;
  logic pcm_stb = 1'b0, ts1 = 1'b0, ts2 = 1'b0, ts_sel = 1'b1;
  logic sup_n = 1'b1, blank = 1'b0;
  logic pcm_out, alarm;

  codir_rx #(.OCT_W(OCT_W), .MISS_LIMIT(MISS_LIMIT)) u_codir_rx (
    .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_half(line_half),
    .line_p_n(line_p_n), .line_n_n(line_n_n), .pcm_stb(pcm_stb),
    .ts1(ts1), .ts2(ts2), .ts_sel(ts_sel), .sup_n(sup_n), .blank(blank),
    .pcm_out(pcm_out), .alarm(alarm)
  );

  int    checks = 0;
  int    errors = 0;
  string req_tag = "R6";
  bit    cmp_en = 1'b0;
  bit    done = 1'b0;
  int    frame_len = 24;
  bit    enc_last = 1'b0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int               cyc;
  bit               m_fm, m_fp, m_pp, m_hp;
  int               m_pos, m_cnt;
  logic [OCT_W-1:0] m_asm, m_new, m_hold;
  bit               m_new_miss, m_hold_miss, m_unread, m_force;
  bit               m_env_prev, m_bit, m_alarm;
  int               m_idx;
  int               aq_t[$];
  bit               aq_v[$];
  int               wq_t[$];
  logic [OCT_W-1:0] wq_d[$];
  bit               wq_m[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0; m_fm = 0; m_fp = 0; m_pp = 0; m_hp = 0;
      m_pos = 0; m_cnt = 0; m_asm = '0; m_new = '1; m_hold = '1;
      m_new_miss = 0; m_hold_miss = 0; m_unread = 0; m_force = 0;
      m_env_prev = 0; m_bit = 1; m_alarm = 0; m_idx = OCT_W;
      aq_t.delete(); aq_v.delete(); wq_t.delete(); wq_d.delete(); wq_m.delete();
    end else begin
      cyc++;
      if (pcm_stb) begin : pcm_side
        bit env;
        env = ts_sel ? ts1 : ts2;
        if (env && !m_env_prev) begin
          if (m_unread) begin
            m_hold = m_new; m_hold_miss = m_new_miss; m_unread = 0;
          end
          m_force = m_hold_miss && !sup_n;
          m_bit = m_hold[0] | m_force;
          m_idx = 1;
        end else if (env && m_idx < OCT_W) begin
          m_bit = m_hold[m_idx] | m_force;
          m_idx++;
        end else begin
          m_bit = 1;
        end
        m_env_prev = env;
      end
      if (aq_t.size() > 0 && aq_t[0] == cyc) begin
        m_alarm = aq_v[0]; void'(aq_t.pop_front()); void'(aq_v.pop_front());
      end
      if (wq_t.size() > 0 && wq_t[0] == cyc) begin
        m_new = wq_d[0]; m_new_miss = wq_m[0]; m_unread = 1;
        void'(wq_t.pop_front()); void'(wq_d.pop_front()); void'(wq_m.pop_front());
      end
      if (line_stb) begin : line_side
        bit any, pos, b, v;
        pos = !line_p_n;
        any = !line_p_n || !line_n_n;
        if (!line_half) begin
          m_fm = any; m_fp = pos;
        end else begin
          b = !any;
          v = m_fm && m_hp && (m_fp == m_pp);
          if (m_fm) begin m_pp = m_fp; m_hp = 1; end
          m_fm = 0;
          if (v && m_pos == OCT_W - 1) begin
            m_asm[m_pos] = b;
            wq_t.push_back(cyc + 2); wq_d.push_back(m_asm); wq_m.push_back(0);
            m_cnt = 0;
            aq_t.push_back(cyc + 1); aq_v.push_back(0);
            m_pos = 0;
          end else if (v) begin
            m_pos = 0;
          end else if (m_pos == OCT_W - 1) begin
            m_asm[m_pos] = b;
            wq_t.push_back(cyc + 2); wq_d.push_back(m_asm); wq_m.push_back(1);
            if (m_cnt < MISS_LIMIT) m_cnt++;
            if (m_cnt == MISS_LIMIT) begin aq_t.push_back(cyc + 1); aq_v.push_back(1); end
            m_pos = 0;
          end else begin
            m_asm[m_pos] = b;
            m_pos++;
          end
        end
      end
    end
  end

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (cmp_en && !done) begin
      check(pcm_out === (m_bit | blank), req_tag, "pcm_out", int'(pcm_out), int'(m_bit | blank));
      check(alarm === m_alarm, req_tag, "alarm", int'(alarm), int'(m_alarm));
    end
  end

  // ---------------- stimulus ----------------
  task automatic send_half(input bit h, input bit mark, input bit pos);
    @(negedge clk);
    line_stb = 1'b1; line_half = h;
    line_p_n = !(mark && pos);
    line_n_n = !(mark && !pos);
    @(negedge clk);
    line_stb = 1'b0; line_p_n = 1'b1; line_n_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic send_bit(input bit b, input bit v);
    bit pol;
    pol = v ? enc_last : !enc_last;
    enc_last = pol;
    send_half(1'b0, 1'b1, pol);
    send_half(1'b1, !b, !pol);
  endtask

  task automatic send_octet(input logic [OCT_W-1:0] d, input int viol_at);
    for (int i = 0; i < OCT_W; i++) send_bit(d[i], i == viol_at);
  endtask

  // PCM strobe every 4 cycles, two envelopes of 8 strobes per frame
  initial begin
    forever begin
      for (int s = 0; s < frame_len; s++) begin
        @(negedge clk);
        pcm_stb = 1'b1;
        ts1 = (s >= 2 && s < 10);
        ts2 = (s >= 12 && s < 20);
        @(negedge clk);
        pcm_stb = 1'b0;
        repeat (2) @(negedge clk);
      end
    end
  end

  task automatic finish_run();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog (all requirements): actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // reset state: idle-high output (R6, R7) and no alarm (R5)
    check(pcm_out === 1'b1, "R6", "reset pcm_out", int'(pcm_out), 1);
    check(alarm === 1'b0, "R5", "reset alarm", int'(alarm), 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R1: rail decoding while framing locks onto violations
    req_tag = "R1";
    for (int i = 0; i < 3; i++) send_octet(8'hA5, 7);
    // R2: mixed ones and zeros
    req_tag = "R2";
    for (int i = 0; i < 6; i++) send_octet(8'(8'h35 + i * 37), 7);
    // R3: violations framing every octet
    req_tag = "R3";
    for (int i = 0; i < 6; i++) send_octet(8'(8'hF0 ^ (i * 11)), 7);

    // R5 and R4: no violations, supervision off, framing keeps running
    req_tag = "R5";
    for (int i = 0; i < 10; i++) send_octet(8'(8'h0F + i * 5), -1);
    check(alarm === 1'b1, "R5", "alarm after missing violations", int'(alarm), 1);

    // R9: supervision on while violations are still missing
    req_tag = "R9";
    sup_n = 1'b0;
    for (int i = 0; i < 3; i++) send_octet(8'(8'h5A + i), -1);

    // R5: violation at the expected bit clears the alarm
    req_tag = "R5";
    for (int i = 0; i < 3; i++) send_octet(8'(8'hC3 + i), 7);
    check(alarm === 1'b0, "R5", "alarm after aligned violation", int'(alarm), 0);
    sup_n = 1'b1;

    // R4: violation on a middle bit realigns framing
    req_tag = "R4";
    send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b0);
    send_bit(1'b1, 1'b1);
    for (int i = 0; i < 4; i++) send_octet(8'(8'h96 + i * 3), 7);
    check(alarm === 1'b0, "R4", "alarm after realign", int'(alarm), 0);

    // R8: direct blanking
    req_tag = "R8";
    blank = 1'b1;
    send_octet(8'h00, 7);
    check(pcm_out === 1'b1, "R8", "pcm_out while blanked", int'(pcm_out), 1);
    send_octet(8'h00, 7);
    blank = 1'b0;

    // R7: local side fast (repeats), then slow (drops)
    req_tag = "R7";
    frame_len = 22;
    for (int i = 0; i < 15; i++) send_octet(8'(i * 29 + 3), 7);
    frame_len = 26;
    for (int i = 0; i < 15; i++) send_octet(8'(i * 13 + 1), 7);
    frame_len = 24;

    // R6: second envelope selected
    req_tag = "R6";
    ts_sel = 1'b0;
    for (int i = 0; i < 5; i++) send_octet(8'(8'h81 + i * 7), 7);

    repeat (200) @(negedge clk);
    finish_run();
  end

endmodule